// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Divider

This block derives the serial clock of an SPI master from its module clock. A packed clock-control word carries two divider fields and a bit that picks which one applies. With the linear law, the serial clock runs at the module clock divided by an even number, twice the 8-bit count plus one. With the power law, it runs at the module clock divided by two raised to the 4-bit exponent plus one. Software chooses the field values. The block only applies them.

Besides the serial clock level, the block gives the shift logic one-cycle strobes. A leading strobe marks the clock leaving its idle level, and a trailing strobe marks it returning to idle. The idle level follows the polarity input. While the enable is low, the clock rests at that level and the half-period counter stays cleared. A divider word written during a transfer takes effect only at the next half-period boundary, so no shortened pulse can appear.

Top module: `sck_divider`

## Requirements
- R1: With the law-select bit (bit 12 of the control word) at 1, every half period of `sck` lasts N2+1 module clock cycles, where N2 is bits [7:0].
- R2: With the law-select bit at 0, every half period lasts 2^N1 module clock cycles, so the full period is 2^(N1+1), where N1 is bits [11:8].
- R3: With the linear law and N2 = 0, `sck` toggles on every module clock edge, which is half the module clock rate.
- R4: While `enable` is low, `sck` equals `cpol` from the next cycle on and both strobes stay low. After `enable` rises, the first toggle comes one full half period after the first enabled clock edge.
- R5: Each toggle raises exactly one strobe for exactly one cycle, in the same cycle the new `sck` level appears. `lead_pulse` marks a move away from `cpol` and `trail_pulse` marks a return to it.
- R6: A control word changed while enabled leaves the half period in progress at its old length. The new length starts with the next half period.
- R7: The field of the law that is not selected has no effect on the period.
- R8: With `cpol` = 1, the idle level is high and the leading strobe goes with a falling `sck` edge.
- R9: Dropping `enable` in the middle of a half period returns `sck` to idle on the next cycle. Re-enabling starts a fresh, full-length half period.
- R10: During reset, `sck`, `lead_pulse` and `trail_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the serial clock. When low, hold it idle |
| cpol | input | 1 | Idle level of the serial clock |
| clk_ctl | input | 13 | Control word: [7:0] linear count, [11:8] exponent, [12] law select (1 = linear) |
| sck | output | 1 | Serial clock level |
| lead_pulse | output | 1 | One-cycle strobe when `sck` leaves idle |
| trail_pulse | output | 1 | One-cycle strobe when `sck` returns to idle |

## Verification
The bench builds the block with its default parameters: an 8-bit linear field and a 4-bit exponent. This reaches both ends of each law: the single-cycle half period at a count of zero, the 256-cycle half period at the top of the linear field, and the 32768-cycle half period at the largest exponent, which exercises the counter's full width. Those widths also keep the mid-transfer divider change and the disable-and-restart cases short enough to measure edge by edge.

// File: rtl/sckdiv_pkg.sv
package sckdiv_pkg;

  typedef enum logic {
    LAW_POW2   = 1'b0,
    LAW_LINEAR = 1'b1
  } law_e;

  function automatic int unsigned wider(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sckdiv_decode.sv
module sckdiv_decode #(
  parameter int unsigned LIN_W = 8,
  parameter int unsigned EXP_W = 4,
  parameter int unsigned CW    = 15
) (
  input  logic [LIN_W+EXP_W:0] ctl,
  output logic [CW-1:0]        half_m1
);
  import sckdiv_pkg::*;

  localparam int unsigned SEL_POS = LIN_W + EXP_W;

  logic [LIN_W-1:0] lin_f;
  logic [EXP_W-1:0] exp_f;
  law_e             law;
  logic [CW:0]      one_sh;
  logic [CW:0]      pow_full;
  logic [CW-1:0]    lin_m1;
  logic [CW-1:0]    pow_m1;

  always_comb begin
    lin_f    = ctl[LIN_W-1:0];
    exp_f    = ctl[SEL_POS-1:LIN_W];
    law      = law_e'(ctl[SEL_POS]);
    lin_m1   = CW'(lin_f);
    one_sh   = (CW+1)'(1) << exp_f;
    pow_full = one_sh - (CW+1)'(1);
    pow_m1   = pow_full[CW-1:0];
    half_m1  = (law == LAW_LINEAR) ? lin_m1 : pow_m1;
  end

endmodule

// File: rtl/sckdiv_count.sv
module sckdiv_count #(
  parameter int unsigned CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] load_val,
  output logic          wrap
);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] lim_q, lim_n;

  assign wrap = en && (cnt_q == lim_q);

  always_comb begin
    cnt_n = cnt_q;
    lim_n = lim_q;
    if (!en) begin
      cnt_n = '0;
      lim_n = load_val;
    end else if (cnt_q == lim_q) begin
      cnt_n = '0;
      lim_n = load_val;
    end else begin
      cnt_n = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      lim_q <= lim_n;
    end
  end

  assert_idle_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= lim_q));

  assert_limit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$past(wrap)) |-> $stable(lim_q));

endmodule

// File: rtl/sckdiv_phase.sv
module sckdiv_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cpol,
  input  logic wrap,
  output logic sck,
  output logic lead,
  output logic trail
);

  logic sck_q, sck_n;
  logic lead_q, lead_n;
  logic trail_q, trail_n;

  always_comb begin
    sck_n   = sck_q;
    lead_n  = 1'b0;
    trail_n = 1'b0;
    if (!en) begin
      sck_n = cpol;
    end else if (wrap) begin
      sck_n   = ~sck_q;
      lead_n  = (sck_q == cpol);
      trail_n = (sck_q != cpol);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      sck_q   <= sck_n;
      lead_q  <= lead_n;
      trail_q <= trail_n;
    end
  end

  assign sck   = sck_q;
  assign lead  = lead_q;
  assign trail = trail_q;

  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ((sck == $past(cpol)) && !lead && !trail));

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead && trail));

  assert_lead_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lead |-> ((sck != $past(sck)) && (sck != $past(cpol))));

  assert_trail_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trail |-> ((sck != $past(sck)) && (sck == $past(cpol))));

  assert_toggle_strobed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && (sck != $past(sck))) |-> (lead || trail));

endmodule

// File: rtl/sck_divider.sv
module sck_divider #(
  parameter int unsigned LIN_W = 8,
  parameter int unsigned EXP_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic                   cpol,
  input  logic [LIN_W+EXP_W:0]   clk_ctl,
  output logic                   sck,
  output logic                   lead_pulse,
  output logic                   trail_pulse
);

  localparam int unsigned CW = sckdiv_pkg::wider(LIN_W, (1 << EXP_W) - 1);

  logic [CW-1:0] half_m1;
  logic          wrap;

  sckdiv_decode #(.LIN_W(LIN_W), .EXP_W(EXP_W), .CW(CW)) u_decode (
    .ctl     (clk_ctl),
    .half_m1 (half_m1)
  );

  sckdiv_count #(.CW(CW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (enable),
    .load_val (half_m1),
    .wrap     (wrap)
  );

  sckdiv_phase u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (enable),
    .cpol  (cpol),
    .wrap  (wrap),
    .sck   (sck),
    .lead  (lead_pulse),
    .trail (trail_pulse)
  );

  always_comb begin
    assert_reset_quiet_R10: assert (rst_n || (!sck && !lead_pulse && !trail_pulse));
  end

endmodule

// File: tb/sck_divider_tb.sv
module sck_divider_tb;

  logic        clk;
  logic        rst_n;
  logic        enable;
  logic        cpol;
  logic [12:0] clk_ctl;
  logic        sck;
  logic        lead_pulse;
  logic        trail_pulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  sck_divider u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .cpol        (cpol),
    .clk_ctl     (clk_ctl),
    .sck         (sck),
    .lead_pulse  (lead_pulse),
    .trail_pulse (trail_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [12:0] mk_ctl(input logic sel, input logic [3:0] n1,
                                         input logic [7:0] n2);
    return {sel, n1, n2};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic wait_toggle(output int n, output logic ld, output logic tr);
    logic prev;
    prev = sck;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (sck != prev || n > 70000) break;
    end
    ld = lead_pulse;
    tr = trail_pulse;
  endtask

  task automatic go_idle();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_halves(input logic [12:0] ctl, input logic pol, input int half,
                            input int nhalf, input string tag);
    int n;
    logic ld, tr;
    go_idle();
    clk_ctl = ctl;
    cpol = pol;
    @(negedge clk);
    @(negedge clk);
    chk(sck == pol, {tag, " idle level"}, sck, pol);
    enable = 1'b1;
    for (int k = 0; k < nhalf; k++) begin
      wait_toggle(n, ld, tr);
      chk(n == half, {tag, " half period"}, n, half);
      chk(sck == ((k % 2 == 0) ? ~pol : pol), {tag, " level"}, sck, (k % 2 == 0) ? ~pol : pol);
      chk(ld == (k % 2 == 0), {tag, " lead strobe"}, ld, k % 2 == 0);
      chk(tr == (k % 2 == 1), {tag, " trail strobe"}, tr, k % 2 == 1);
    end
    if (half > 1) begin
      @(negedge clk);
      chk(!lead_pulse && !trail_pulse, {tag, " strobe one cycle"}, lead_pulse | trail_pulse, 0);
    end
    go_idle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    enable = 1'b0;
    cpol = 1'b1;
    clk_ctl = mk_ctl(1'b1, 4'd0, 8'd3);
    repeat (3) @(negedge clk);
    chk(!sck && !lead_pulse && !trail_pulse, "R10 reset outputs", {sck, lead_pulse, trail_pulse}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sck == 1'b1, "R4 idle after reset follows cpol", sck, 1);
  endtask

  task automatic t_idle();
    int bad = 0;
    cpol = 1'b0;
    enable = 1'b0;
    clk_ctl = mk_ctl(1'b1, 4'd0, 8'd0);
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sck != 1'b0 || lead_pulse || trail_pulse) bad++;
    end
    chk(bad == 0, "R4 disabled holds idle without strobes", bad, 0);
  endtask

  task automatic t_midchange();
    int n;
    logic ld, tr;
    go_idle();
    cpol = 1'b0;
    clk_ctl = mk_ctl(1'b1, 4'd0, 8'd9);
    @(negedge clk);
    enable = 1'b1;
    wait_toggle(n, ld, tr);
    chk(n == 10, "R6 first half before change", n, 10);
    repeat (3) @(negedge clk);
    clk_ctl = mk_ctl(1'b1, 4'd0, 8'd3);
    wait_toggle(n, ld, tr);
    chk(n == 7, "R6 running half keeps old length", n, 7);
    wait_toggle(n, ld, tr);
    chk(n == 4, "R6 next half uses new length", n, 4);
    go_idle();
  endtask

  task automatic t_disable_mid();
    int n;
    logic ld, tr;
    go_idle();
    cpol = 1'b0;
    clk_ctl = mk_ctl(1'b1, 4'd0, 8'd5);
    @(negedge clk);
    enable = 1'b1;
    wait_toggle(n, ld, tr);
    chk(sck == 1'b1, "R9 active level before disable", sck, 1);
    repeat (2) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(sck == 1'b0 && !lead_pulse && !trail_pulse, "R9 disable returns idle", sck, 0);
    @(negedge clk);
    enable = 1'b1;
    wait_toggle(n, ld, tr);
    chk(n == 6, "R9 restart full half period", n, 6);
    chk(ld == 1'b1, "R9 restart leading strobe", ld, 1);
    go_idle();
  endtask

  initial begin
    t_reset();
    t_idle();
    run_halves(mk_ctl(1'b1, 4'd0, 8'd4),   1'b0, 5,     4, "R1 linear n2=4");
    run_halves(mk_ctl(1'b1, 4'd0, 8'd255), 1'b0, 256,   2, "R1 linear n2=255");
    run_halves(mk_ctl(1'b1, 4'd0, 8'd0),   1'b0, 1,     6, "R3 linear n2=0");
    run_halves(mk_ctl(1'b0, 4'd0, 8'd0),   1'b0, 1,     4, "R2 pow n1=0");
    run_halves(mk_ctl(1'b0, 4'd3, 8'd0),   1'b0, 8,     4, "R2 pow n1=3");
    run_halves(mk_ctl(1'b0, 4'd15, 8'd0),  1'b0, 32768, 2, "R2 pow n1=15");
    run_halves(mk_ctl(1'b1, 4'd9, 8'd2),   1'b0, 3,     2, "R7 linear ignores exponent");
    run_halves(mk_ctl(1'b0, 4'd2, 8'd200), 1'b0, 4,     2, "R7 pow ignores count");
    run_halves(mk_ctl(1'b1, 4'd0, 8'd2),   1'b1, 3,     4, "R8 cpol=1 linear");
    run_halves(mk_ctl(1'b0, 4'd1, 8'd0),   1'b1, 2,     2, "R8 cpol=1 pow");
    t_midchange();
    t_disable_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule